// File: doc/BRIEF.md
# Coprocessor Start Gate with Instruction-Cache Line Tracker

This block rules on each request to launch a coprocessor run. It looks at the program counter, the program bank and two enable bits in a mode byte. An accepted request raises a one-cycle start strobe and a one-cycle request to clear the interrupt flag. A refused request raises a one-cycle request to clear the running ("go") flag. The ruling appears one clock after the request.

The block also holds the bookkeeping for a 512-byte instruction cache. This is a 32-bit map of valid 16-byte lines, an active bit and a 16-bit base address. While the cache is active, any start address that falls inside the cached window is accepted whatever the bank is. Two flush commands are provided. The full flush clears the map, the active bit and the base. The light flush keeps the base.

Top module: `start_gate_top`

## Requirements
- R1: When `cache_active` is 1 and `base <= pc < base + 512` (computed without wrap-around), a request is accepted regardless of bank and mode.
- R2: Outside a cache hit, banks 0x60 to 0x6F and every bank of 0x74 or higher are refused.
- R3: Outside a cache hit, banks 0x70 to 0x73 are accepted only when `mode` bit 3 is 1.
- R4: Outside a cache hit, all remaining banks (0x00 to 0x5F and 0x74 excluded) are accepted only when `mode` bit 4 is 1.
- R5: The cycle after a request, an accept drives `start_strobe` and `irq_clear` high and a refusal drives `go_clear` high. Each of these pulses lasts one cycle. Accept and refusal never occur together, and in the cycle after a cycle with no request all three are low.
- R6: A cache write whose offset has bits 3:0 equal to 0xF sets `line_valid[offset[8:4]]` on the next cycle. Any other write offset leaves the map unchanged.
- R7: A full flush clears `line_valid`, `cache_active` and `cache_base` on the next cycle.
- R8: A light flush clears `line_valid` and `cache_active` and leaves `cache_base` unchanged.
- R9: A flush wins over a line write, a base load or an activation that arrives in the same cycle.
- R10: After reset all outputs are 0. `base_ld` loads `base_din` into `cache_base`, and `act_set` sets `cache_active`, each on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to begin a run |
| pc | input | 16 | Start program counter |
| prog_bank | input | 8 | Program bank of the start address |
| mode | input | 8 | Mode byte; bit 3 enables RAM, bit 4 enables ROM |
| cache_wr | input | 1 | A byte is being written into the cache |
| cache_wr_ofs | input | 9 | Byte offset of that write inside the cache |
| base_ld | input | 1 | Load the cache base |
| base_din | input | 16 | New cache base value |
| act_set | input | 1 | Mark the cache active |
| flush_full | input | 1 | Full flush |
| flush_light | input | 1 | Light flush (base kept) |
| start_strobe | output | 1 | Run accepted, one-cycle pulse |
| irq_clear | output | 1 | Clear interrupt flag, one-cycle pulse |
| go_clear | output | 1 | Clear go flag (refused), one-cycle pulse |
| line_valid | output | 32 | Per-line valid map |
| cache_active | output | 1 | Cache active bit |
| cache_base | output | 16 | Cache base address |

## Verification
The assertions assume that `pc`, `prog_bank` and `mode` hold steady for the whole cycle in which `start_req` is high. They also assume that the flush inputs are ordinary one-cycle commands. The stimulus holds each request for exactly one cycle, with every input driven half a period away from the capturing edge. Flush and write collisions are created on purpose and are always expected to resolve in favour of the flush. The bench sweeps every bank under all four enable combinations and every cache offset. It also probes the window edges, including a base near 0xFFFF, where the upper bound must not wrap.

// File: rtl/start_gate_pkg.sv
package start_gate_pkg;
   typedef enum logic [1:0] {
      AREA_VOID = 2'd0,
      AREA_RAM  = 2'd1,
      AREA_ROM  = 2'd2
   } area_e;
endpackage

// File: rtl/bank_screen.sv
module bank_screen
   import start_gate_pkg::*;
#(
   parameter int BANK_W     = 8,
   parameter int MODE_W     = 8,
   parameter int VOID_LO    = 'h60,
   parameter int VOID_HI    = 'h6F,
   parameter int RAM_LO     = 'h70,
   parameter int RAM_HI     = 'h73,
   parameter int RAM_EN_BIT = 3,
   parameter int ROM_EN_BIT = 4
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [MODE_W-1:0] mode,
   output area_e             area,
   output logic              bank_ok
);
   localparam logic [BANK_W-1:0] VLO = BANK_W'(VOID_LO);
   localparam logic [BANK_W-1:0] VHI = BANK_W'(VOID_HI);
   localparam logic [BANK_W-1:0] RLO = BANK_W'(RAM_LO);
   localparam logic [BANK_W-1:0] RHI = BANK_W'(RAM_HI);

   if (RAM_EN_BIT >= MODE_W || ROM_EN_BIT >= MODE_W) begin : g_bad_bits
      $error("enable bit outside mode byte");
   end
   if (RAM_LO > RAM_HI || VOID_LO > VOID_HI) begin : g_bad_range
      $error("bank range inverted");
   end

   always_comb begin
      if (bank >= VLO && bank <= VHI)
         area = AREA_VOID;
      else if (bank > RHI)
         area = AREA_VOID;
      else if (bank >= RLO)
         area = AREA_RAM;
      else
         area = AREA_ROM;
   end

   always_comb begin
      unique case (area)
         AREA_RAM: bank_ok = mode[RAM_EN_BIT];
         AREA_ROM: bank_ok = mode[ROM_EN_BIT];
         default:  bank_ok = 1'b0;
      endcase
   end

   logic unused_mode;
   assign unused_mode = ^mode;
endmodule

// File: rtl/cache_tracker.sv
module cache_tracker #(
   parameter int LINE_BYTES = 16,
   parameter int NUM_LINES  = 32,
   parameter int ADDR_W     = 16,
   localparam int OFS_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(NUM_LINES),
   localparam int CWA_W     = OFS_W + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cache_wr,
   input  logic [CWA_W-1:0]     cache_wr_ofs,
   input  logic                 base_ld,
   input  logic [ADDR_W-1:0]    base_din,
   input  logic                 act_set,
   input  logic                 flush_full,
   input  logic                 flush_light,
   output logic [NUM_LINES-1:0] line_valid,
   output logic                 cache_active,
   output logic [ADDR_W-1:0]    cache_base
);
   if ((1 << OFS_W) != LINE_BYTES || (1 << IDX_W) != NUM_LINES) begin : g_bad_geom
      $error("line size and line count must be powers of two");
   end

   logic             flush_any;
   logic             last_byte;
   logic [IDX_W-1:0] wr_idx;

   assign flush_any = flush_full | flush_light;
   assign last_byte = cache_wr && (cache_wr_ofs[OFS_W-1:0] == {OFS_W{1'b1}});
   assign wr_idx    = cache_wr_ofs[CWA_W-1:OFS_W];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)
            line_valid[i] <= 1'b0;
         else if (flush_any)
            line_valid[i] <= 1'b0;
         else if (last_byte && wr_idx == IDX_W'(i))
            line_valid[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cache_active <= 1'b0;
         cache_base   <= '0;
      end else begin
         if (flush_any)
            cache_active <= 1'b0;
         else if (act_set)
            cache_active <= 1'b1;
         if (flush_full)
            cache_base <= '0;
         else if (base_ld && !flush_light)
            cache_base <= base_din;
      end
   end

   // R6
   line_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte && !flush_any |=> line_valid[$past(wr_idx)]);
   // R7
   full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_full |=> line_valid == '0 && !cache_active && cache_base == '0);
   // R8
   light_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_light && !flush_full |=> line_valid == '0 && !cache_active && $stable(cache_base));
   // R10
   base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_ld && !flush_any |=> cache_base == $past(base_din));
endmodule

// File: rtl/start_decider.sv
module start_decider #(
   parameter int ADDR_W     = 16,
   parameter int CACHE_SPAN = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [ADDR_W-1:0] pc,
   input  logic              cache_active,
   input  logic [ADDR_W-1:0] cache_base,
   input  logic              bank_ok,
   output logic              start_strobe,
   output logic              irq_clear,
   output logic              go_clear
);
   localparam int          SUM_W = ADDR_W + 1;
   localparam logic [SUM_W-1:0] SPAN = SUM_W'(CACHE_SPAN);

   if (CACHE_SPAN <= 0 || CACHE_SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("cache span out of range");
   end

   logic [SUM_W-1:0] pc_x, lo_x, hi_x;
   logic             win_hit, accept;

   assign pc_x    = {1'b0, pc};
   assign lo_x    = {1'b0, cache_base};
   assign hi_x    = lo_x + SPAN;
   assign win_hit = cache_active && (pc_x >= lo_x) && (pc_x < hi_x);
   assign accept  = win_hit || bank_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_strobe <= 1'b0;
         irq_clear    <= 1'b0;
         go_clear     <= 1'b0;
      end else begin
         start_strobe <= start_req && accept;
         irq_clear    <= start_req && accept;
         go_clear     <= start_req && !accept;
      end
   end

   // R1
   window_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && win_hit |=> start_strobe);
   // R5
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_strobe && go_clear));
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_req |=> !start_strobe && !irq_clear && !go_clear);
   // R5
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_strobe && !$past(start_req) |-> 1'b0);
endmodule

// File: rtl/start_gate_top.sv
module start_gate_top
   import start_gate_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BANK_W     = 8,
   parameter int MODE_W     = 8,
   parameter int LINE_BYTES = 16,
   parameter int NUM_LINES  = 32,
   localparam int CWA_W     = $clog2(LINE_BYTES) + $clog2(NUM_LINES),
   localparam int SPAN      = LINE_BYTES * NUM_LINES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_req,
   input  logic [ADDR_W-1:0]    pc,
   input  logic [BANK_W-1:0]    prog_bank,
   input  logic [MODE_W-1:0]    mode,
   input  logic                 cache_wr,
   input  logic [CWA_W-1:0]     cache_wr_ofs,
   input  logic                 base_ld,
   input  logic [ADDR_W-1:0]    base_din,
   input  logic                 act_set,
   input  logic                 flush_full,
   input  logic                 flush_light,
   output logic                 start_strobe,
   output logic                 irq_clear,
   output logic                 go_clear,
   output logic [NUM_LINES-1:0] line_valid,
   output logic                 cache_active,
   output logic [ADDR_W-1:0]    cache_base
);
   area_e area;
   logic  bank_ok;

   bank_screen #(.BANK_W(BANK_W), .MODE_W(MODE_W)) u_screen (
      .bank(prog_bank), .mode(mode), .area(area), .bank_ok(bank_ok));

   cache_tracker #(.LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_cache (
      .clk(clk), .rst_n(rst_n), .cache_wr(cache_wr), .cache_wr_ofs(cache_wr_ofs),
      .base_ld(base_ld), .base_din(base_din), .act_set(act_set),
      .flush_full(flush_full), .flush_light(flush_light),
      .line_valid(line_valid), .cache_active(cache_active), .cache_base(cache_base));

   start_decider #(.ADDR_W(ADDR_W), .CACHE_SPAN(SPAN)) u_dec (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .pc(pc),
      .cache_active(cache_active), .cache_base(cache_base), .bank_ok(bank_ok),
      .start_strobe(start_strobe), .irq_clear(irq_clear), .go_clear(go_clear));

   // R2
   void_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && !cache_active && area == AREA_VOID |=> go_clear);
   // R9
   flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_full || flush_light) && act_set |=> !cache_active);
endmodule

// File: tb/sim_start_gate_top.sv
`timescale 1ns/1ps
module sim_start_gate_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_req = 1'b0;
   logic [15:0] pc = '0;
   logic [7:0]  prog_bank = '0;
   logic [7:0]  mode = '0;
   logic        cache_wr = 1'b0;
   logic [8:0]  cache_wr_ofs = '0;
   logic        base_ld = 1'b0;
   logic [15:0] base_din = '0;
   logic        act_set = 1'b0;
   logic        flush_full = 1'b0;
   logic        flush_light = 1'b0;
   logic        start_strobe, irq_clear, go_clear, cache_active;
   logic [31:0] line_valid;
   logic [15:0] cache_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [31:0] mdl_valid = '0;

   always #2.5 clk = ~clk;

   start_gate_top u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic try_start(input logic [15:0] p, input logic [7:0] b, input logic [7:0] m,
                            input bit exp_acc, input string tag);
      pc = p; prog_bank = b; mode = m; start_req = 1'b1;
      tick();
      start_req = 1'b0;
      chk(start_strobe == exp_acc && irq_clear == exp_acc && go_clear == !exp_acc, tag,
          {29'd0, start_strobe, irq_clear, go_clear}, {29'd0, exp_acc, exp_acc, !exp_acc});
   endtask

   function automatic bit bank_rule(input logic [7:0] b, input logic [7:0] m);
      if ((b >= 8'h60 && b <= 8'h6F) || b >= 8'h74) return 1'b0;
      if (b >= 8'h70) return m[3];
      return m[4];
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R10 reset state
      chk(line_valid == 0 && !cache_active && cache_base == 0, "R10 reset",
          {line_valid[15:0], cache_base}, 32'd0);
      chk({start_strobe, irq_clear, go_clear} == 3'b000, "R5 idle after reset",
          {29'd0, start_strobe, irq_clear, go_clear}, 32'd0);

      // R2 R3 R4 bank sweep, cache inactive
      for (int mi = 0; mi < 4; mi++) begin
         for (int b = 0; b < 256; b++) begin
            logic [7:0] m;
            m = 8'((mi[0] << 3) | (mi[1] << 4)) | 8'hE7;
            try_start(16'h1234, 8'(b), m, bank_rule(8'(b), m),
               (b >= 'h60 && b <= 'h6F) || b >= 'h74 ? "R2 bank" :
               (b >= 'h70 ? "R3 ram bank" : "R4 rom bank"));
         end
      end
      // R5 no request
      tick();
      chk({start_strobe, irq_clear, go_clear} == 3'b000, "R5 no request",
          {29'd0, start_strobe, irq_clear, go_clear}, 32'd0);

      // R10 base load and activation
      base_ld = 1'b1; base_din = 16'h1000; act_set = 1'b1;
      tick();
      base_ld = 1'b0; act_set = 1'b0;
      chk(cache_base == 16'h1000 && cache_active, "R10 load",
          {15'd0, cache_active, cache_base}, {15'd0, 1'b1, 16'h1000});

      // R1 window edges with refused bank
      try_start(16'h0FFF, 8'h65, 8'h00, 1'b0, "R1 below window");
      try_start(16'h1000, 8'h65, 8'h00, 1'b1, "R1 window start");
      try_start(16'h11FF, 8'hFF, 8'h00, 1'b1, "R1 window end");
      try_start(16'h1200, 8'h71, 8'h00, 1'b0, "R1 past window");

      // R6 offset sweep
      for (int a = 0; a < 512; a++) begin
         cache_wr = 1'b1; cache_wr_ofs = 9'(a);
         if ((a & 15) == 15) mdl_valid[a >> 4] = 1'b1;
         tick();
         chk(line_valid == mdl_valid, "R6 line map", line_valid, mdl_valid);
      end
      cache_wr = 1'b0;

      // R8 light flush keeps base
      flush_light = 1'b1;
      tick();
      flush_light = 1'b0;
      mdl_valid = '0;
      chk(line_valid == 0 && !cache_active && cache_base == 16'h1000, "R8 light flush",
          {line_valid[14:0], cache_active, cache_base}, {16'd0, 16'h1000});
      try_start(16'h1000, 8'h65, 8'h18, 1'b0, "R1 inactive cache");

      // R9 flush beats write, base load and activation
      cache_wr = 1'b1; cache_wr_ofs = 9'h02F; base_ld = 1'b1; base_din = 16'h2222;
      act_set = 1'b1; flush_light = 1'b1;
      tick();
      cache_wr = 1'b0; base_ld = 1'b0; act_set = 1'b0; flush_light = 1'b0;
      chk(line_valid == 0 && !cache_active && cache_base == 16'h1000, "R9 light collision",
          {line_valid[14:0], cache_active, cache_base}, {16'd0, 16'h1000});

      // base near top, no wrap
      base_ld = 1'b1; base_din = 16'hFF00; act_set = 1'b1;
      cache_wr = 1'b1; cache_wr_ofs = 9'h1FF;
      tick();
      base_ld = 1'b0; act_set = 1'b0; cache_wr = 1'b0;
      chk(line_valid == 32'h8000_0000, "R6 top line", line_valid, 32'h8000_0000);
      try_start(16'hFFFF, 8'h60, 8'h00, 1'b1, "R1 top of space");
      try_start(16'h0000, 8'h60, 8'h00, 1'b0, "R1 no wrap");

      // R7 full flush, colliding with a write
      flush_full = 1'b1; cache_wr = 1'b1; cache_wr_ofs = 9'h00F; base_ld = 1'b1;
      base_din = 16'h3333;
      tick();
      flush_full = 1'b0; cache_wr = 1'b0; base_ld = 1'b0;
      chk(line_valid == 0 && !cache_active && cache_base == 0, "R7 full flush R9",
          {line_valid[14:0], cache_active, cache_base}, 32'd0);
      tick();
      chk(line_valid == 0, "R9 write dropped", line_valid, 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule